// File: doc/BRIEF.md
# Serial Three-Wire Memory Slave

This block is the slave side of a three-wire serial memory link (select, shift clock, data in) with a data-out pin and its output enable. Behind the link sits a 4096-bit store built from registers. A parameter sets the store's shape: 512 bytes or 256 sixteen-bit words. The host selects the block, clocks in a frame, and then either clocks read data out or clocks write data in. Writes, single erases, whole-array erases and whole-array fills run as a self-timed cycle. That cycle starts when the host deselects the block. While the cycle runs, the data-out pin reports busy or ready.

A fast system clock samples the select, shift clock and data pins through a synchronizer, and the block acts on the rising edges of the synchronized shift clock. Every field of a frame is shifted MSB first: a start bit of 1, a 2-bit opcode, then the address (9 bits for bytes, 8 bits for words). The serial pins carry no valid/ready pairing and no back-pressure. The host sets the pace with the shift clock and must not clock faster than the synchronizer can follow. No stream interface exists at the block's edge.

Top module: `sermem_slave`

## Requirements
- R1: After reset, do_oe is 0, writes are disabled, the block is not busy, and every location reads all ones.
- R2: While selected and idle, a DI of 0 at a shift-clock rise is skipped. The first DI of 1 is the start bit. The next 2 bits are the opcode and the bits after that are the address, all MSB first. Opcode 10 reads, 01 writes and 11 erases one location. Opcode 00 takes its action from the two address MSBs: 11 enables writes, 00 disables them, 10 erases all and 01 fills all.
- R3: After the last address bit of a read, DO is driven with a 0 dummy bit. Each later shift-clock rise drives the next data bit, MSB first.
- R4: If the host keeps clocking after a read word, the next address follows. The address after the top location is 0.
- R5: While select is low, do_oe is 0. Dropping select abandons any frame in progress.
- R6: Writes are disabled after reset. While writes are disabled, write, erase, erase-all and fill-all frames change nothing and start no cycle. The enable frame turns writes on and the disable frame turns them off. Reads work in either state.
- R7: A complete write frame plus one data word stores that word at its address, and the store happens only when select falls.
- R8: Data words after the first go to the next addresses of the same page. A page is 16 bytes (the low 4 address bits) or 8 words (the low 3 bits), and the address wraps from the last slot of the page to the first. When a slot gets more than one word, the last word wins.
- R9: An erase sets the addressed location to all ones.
- R10: Erase-all sets every location to all ones. Fill-all writes its data word to every location.
- R11: A started cycle lasts BUSY_CYCLES clock cycles. While the block is selected, DO reads 0 during the cycle and 1 after it. The 1 stays on DO across later selections until a start bit is clocked in.
- R12: Frames clocked in during a cycle are ignored.
- R13: A frame cut short by select falling (a partial header, or a write with no complete data word) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Select, active high |
| sk | input | 1 | Shift clock, acted on at its rising edge |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out (read data or ready/busy) |
| do_oe | output | 1 | Output enable for do_o |

## Verification
Each pin change reaches the logic two clock cycles later through the synchronizer. The state that results from a shift-clock rise then shows on DO about three cycles after that rise. The bench holds each shift-clock half period for four cycles and samples DO just before the next rise, so every bit is read after it has settled. A cycle that starts at deselect raises busy about four cycles after select falls. The bench counts cycles from that fall until DO reads ready and expects a count between BUSY_CYCLES and BUSY_CYCLES+10. After dropping select the bench waits eight cycles before it checks that DO is released or reads the store again.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CMD,
    ST_READ,
    ST_WDATA,
    ST_HOLD
  } sm_state_e;

  typedef enum logic [1:0] {
    PD_NONE,
    PD_PAGE,
    PD_FILL
  } sm_pend_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_WOFF = 2'b00;
  localparam logic [1:0] SUB_FILL = 2'b01;
  localparam logic [1:0] SUB_CLR  = 2'b10;
  localparam logic [1:0] SUB_WON  = 2'b11;
endpackage

// File: rtl/sm_sync.sv
module sm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sm_cycle_timer.sv
module sm_cycle_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int TW = $clog2(CYCLES + 1);
  logic [TW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         left <= '0;
    else if (start)     left <= TW'(CYCLES);
    else if (left != 0) left <= left - 1'b1;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/sm_store.sv
module sm_store #(
  parameter int AW = 9,
  parameter int DW = 8,
  parameter int PB = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          raddr,
  output logic [DW-1:0]          rdata,
  input  logic                   page_we,
  input  logic [AW-PB-1:0]       page_base,
  input  logic [(1<<PB)*DW-1:0]  page_data,
  input  logic [(1<<PB)-1:0]     page_mask,
  input  logic                   fill_we,
  input  logic [DW-1:0]          fill_data
);
  localparam int DEPTH = 1 << AW;
  localparam int NSLOT = 1 << PB;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (fill_we) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= fill_data;
    end else if (page_we) begin
      for (int s = 0; s < NSLOT; s++)
        if (page_mask[s]) mem[{page_base, PB'(s)}] <= page_data[s*DW +: DW];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sermem_slave.sv
module sermem_slave
  import sm_pkg::*;
#(
  parameter bit WIDE        = 1'b0,
  parameter int BUSY_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int AW    = WIDE ? 8 : 9;
  localparam int DW    = WIDE ? 16 : 8;
  localparam int PB    = WIDE ? 3 : 4;
  localparam int NSLOT = 1 << PB;
  localparam int FW    = 2 + AW;
  localparam int MAXB  = (FW > DW) ? FW : DW;
  localparam int CW    = $clog2(MAXB + 1);

  logic cs_lvl, sk_lvl, di_s, sk_prev, sk_rise;

  sm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs, sk, di}), .q({cs_lvl, sk_lvl, di_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_prev <= 1'b0;
    else        sk_prev <= sk_lvl;
  end
  assign sk_rise = sk_lvl & ~sk_prev;

  sm_state_e            st;
  sm_pend_e             pend;
  logic [CW-1:0]        cnt;
  logic [FW-2:0]        cmd_sh;
  logic [DW-2:0]        wsh;
  logic [AW-1:0]        ptr;
  logic                 dummy, armed, wen, wall_ok;
  logic [AW-PB-1:0]     pbase;
  logic [NSLOT*DW-1:0]  pbuf;
  logic [NSLOT-1:0]     pmask;
  logic [PB-1:0]        slot;
  logic [DW-1:0]        wall;
  logic                 page_we, fill_we, tmr_start, busy;
  logic [DW-1:0]        rdata, rd_sh;

  logic [FW-1:0] frame_w;
  logic [1:0]    op_w, sub_w;
  logic [AW-1:0] addr_w;
  logic [DW-1:0] word_w;

  assign frame_w = {cmd_sh, di_s};
  assign op_w    = frame_w[FW-1 -: 2];
  assign addr_w  = frame_w[AW-1:0];
  assign sub_w   = addr_w[AW-1 -: 2];
  assign word_w  = {wsh, di_s};

  sm_store #(.AW(AW), .DW(DW), .PB(PB)) u_store (
    .clk(clk), .rst_n(rst_n), .raddr(ptr), .rdata(rdata),
    .page_we(page_we), .page_base(pbase), .page_data(pbuf), .page_mask(pmask),
    .fill_we(fill_we), .fill_data(wall)
  );

  sm_cycle_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  pend <= PD_NONE;  cnt <= '0;  cmd_sh <= '0;  wsh <= '0;
      ptr <= '0;  dummy <= 1'b0;  armed <= 1'b0;  wen <= 1'b0;  wall_ok <= 1'b0;
      pbase <= '0;  pbuf <= '0;  pmask <= '0;  slot <= '0;  wall <= '0;
      page_we <= 1'b0;  fill_we <= 1'b0;  tmr_start <= 1'b0;
    end else begin
      page_we   <= 1'b0;
      fill_we   <= 1'b0;
      tmr_start <= 1'b0;
      if (!cs_lvl) begin
        // deselect: drop the frame, launch any completed modifying command
        st   <= ST_IDLE;
        pend <= PD_NONE;
        if (pend == PD_PAGE && pmask != '0) begin
          page_we <= 1'b1;  tmr_start <= 1'b1;  armed <= 1'b1;
        end else if (pend == PD_FILL && wall_ok) begin
          fill_we <= 1'b1;  tmr_start <= 1'b1;  armed <= 1'b1;
        end
      end else begin
        unique case (st)
          ST_IDLE: st <= ST_WAIT;
          ST_WAIT: if (sk_rise && !busy && di_s) begin
            armed <= 1'b0;
            cnt   <= '0;
            st    <= ST_CMD;
          end
          ST_CMD: if (sk_rise) begin
            cmd_sh <= frame_w[FW-2:0];
            cnt    <= cnt + 1'b1;
            if (cnt == CW'(FW - 1)) begin
              cnt <= '0;
              st  <= ST_HOLD;
              unique case (op_w)
                OP_READ: begin
                  st <= ST_READ;  ptr <= addr_w;  dummy <= 1'b1;
                end
                OP_WRITE: if (wen) begin
                  pend <= PD_PAGE;  pmask <= '0;  pbase <= addr_w[AW-1:PB];
                  slot <= addr_w[PB-1:0];  st <= ST_WDATA;
                end
                OP_ERASE: if (wen) begin
                  pend  <= PD_PAGE;  pbuf <= '1;  pbase <= addr_w[AW-1:PB];
                  pmask <= NSLOT'(1) << addr_w[PB-1:0];
                end
                default: unique case (sub_w)
                  SUB_WON:  wen <= 1'b1;
                  SUB_WOFF: wen <= 1'b0;
                  SUB_CLR:  if (wen) begin
                    pend <= PD_FILL;  wall <= '1;  wall_ok <= 1'b1;
                  end
                  default:  if (wen) begin
                    pend <= PD_FILL;  wall_ok <= 1'b0;  st <= ST_WDATA;
                  end
                endcase
              endcase
            end
          end
          ST_READ: if (sk_rise) begin
            if (dummy) begin
              dummy <= 1'b0;  cnt <= '0;
            end else if (cnt == CW'(DW - 1)) begin
              cnt <= '0;  ptr <= ptr + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_WDATA: if (sk_rise) begin
            wsh <= word_w[DW-2:0];
            if (cnt == CW'(DW - 1)) begin
              cnt <= '0;
              if (pend == PD_PAGE) begin
                pbuf[slot*DW +: DW] <= word_w;
                pmask[slot]         <= 1'b1;
                slot                <= slot + 1'b1;
              end else begin
                wall <= word_w;  wall_ok <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_sh = rdata << cnt;
  assign do_oe = (st == ST_READ) || (st == ST_WAIT && armed);
  assign do_o  = (st == ST_READ) ? (!dummy && rd_sh[DW-1]) : !busy;
endmodule

// File: rtl/sermem_slave_chk.sv
module sermem_slave_chk
  import sm_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cs_lvl,
  input logic      do_oe,
  input logic      busy,
  input logic      page_we,
  input logic      fill_we,
  input logic      wen,
  input sm_state_e st
);
  // R5
  oe_off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_lvl |=> !do_oe);

  // R3
  read_drives_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ) |-> do_oe);

  // R6
  modify_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_we || fill_we) |-> wen);

  // R11
  modify_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_we || fill_we) |=> busy);

  // R12
  no_frame_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st != ST_CMD));

  // R7
  cycle_follows_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cs_lvl, 2));

  // R10
  single_update_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(page_we && fill_we));
endmodule

bind sermem_slave sermem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .do_oe(do_oe), .busy(busy),
  .page_we(page_we), .fill_we(fill_we), .wen(wen), .st(st)
);

// File: tb/sim_sermem_slave.sv
module sim_sermem_slave;
  localparam int BUSY = 400;
  localparam int H    = 4;
  localparam int N    = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int   nchk = 0, nerr = 0;
  int   model [N];

  always #5 clk = ~clk;

  sermem_slave #(.WIDE(1'b0), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    di = b; tick(H); sk = 1'b1; tick(H); sk = 1'b0;
  endtask

  task automatic frame(input logic [1:0] op, input logic [8:0] a);
    cs = 1'b1; tick(H);
    clk_bit(1'b1); clk_bit(op[1]); clk_bit(op[0]);
    for (int i = 8; i >= 0; i--) clk_bit(a[i]);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) clk_bit(v[i]);
  endtask

  task automatic desel();
    cs = 1'b0; di = 1'b0; tick(2 * H);
  endtask

  task automatic read_seq(input int a, input int n, input string tag);
    logic [7:0] w;
    frame(2'b10, 9'(a));
    chk({tag, " R3 dummy"}, {do_oe, do_o}, 2'b10);
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int b = 0; b < 8; b++) begin
        clk_bit(1'b0);
        w = {w[6:0], do_o};
      end
      chk(tag, w, model[(a + k) % N]);
    end
    desel();
    chk("R5 DO released", do_oe, 0);
  endtask

  task automatic wait_ready();
    int n;
    cs = 1'b1; n = 0;
    while (!(do_oe && do_o) && n < 5000) begin tick(1); n++; end
    desel();
  endtask

  task automatic commit_poll(input string tag);
    int n;
    cs = 1'b0; di = 1'b0; n = 0;
    repeat (2 * H) begin tick(1); n++; end
    cs = 1'b1; tick(H); n += H;
    chk({tag, " R11 busy"}, {do_oe, do_o}, 2'b10);
    while (!(do_oe && do_o) && n < 5000) begin tick(1); n++; end
    chk({tag, " R11 duration"}, int'(n >= BUSY && n <= BUSY + 10), 1);
    cs = 1'b0; tick(2 * H); cs = 1'b1; tick(H);
    chk({tag, " R11 ready held"}, {do_oe, do_o}, 2'b11);
    clk_bit(1'b1);
    chk({tag, " R11 start clears"}, do_oe, 0);
    desel();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 'hFF;
    tick(5); rst_n = 1'b1; tick(4);
    // R1 reset state
    chk("R1 oe", do_oe, 0);
    read_seq(0, 2, "R1 erased");
    read_seq(9'h1F0, 1, "R1 erased top");

    // R6 write ignored while disabled; R2 leading zeros before start bit
    frame(2'b01, 9'h003); send_byte(8'h12); desel();
    cs = 1'b1; tick(H); chk("R6 no cycle started", do_oe, 0); desel();
    cs = 1'b1; tick(H); clk_bit(1'b0); clk_bit(1'b0); cs = 1'b0;
    read_seq(3, 1, "R6 disabled write");

    // enable writes (sub-code 11)
    frame(2'b00, 9'h180); desel();

    // R7 single write
    frame(2'b01, 9'h1A5); send_byte(8'h3C);
    commit_poll("R7");
    model[9'h1A5] = 'h3C;
    read_seq(9'h1A5, 1, "R7 write");

    // R9 erase one location
    frame(2'b11, 9'h1A5); commit_poll("R9");
    model[9'h1A5] = 'hFF;
    read_seq(9'h1A5, 1, "R9 erase");

    // R12 frame during a cycle is ignored
    frame(2'b01, 9'h010); send_byte(8'h55);
    cs = 1'b0; tick(2 * H);
    frame(2'b01, 9'h011); send_byte(8'hAA);
    cs = 1'b0; tick(2 * H);
    wait_ready();
    model[9'h010] = 'h55;
    read_seq(9'h010, 2, "R12 busy frame ignored");

    // R8 page write wrap inside the page, last word wins
    frame(2'b01, 9'h045);
    for (int k = 0; k < 18; k++) begin
      send_byte(8'(8'hA0 + k));
      model[9'h040 + ((5 + k) % 16)] = 'hA0 + k;
    end
    commit_poll("R8");
    read_seq(9'h040, 17, "R8 page wrap");

    // R13 truncated frames
    frame(2'b01, 9'h100); for (int i = 0; i < 5; i++) clk_bit(1'b0); desel();
    cs = 1'b1; tick(H); chk("R13 no cycle", do_oe, 0); desel();
    cs = 1'b1; tick(H); clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1); desel();
    read_seq(9'h100, 1, "R13 partial write");

    // R10 fill all then R4 wrap from top
    frame(2'b00, 9'h080); send_byte(8'h5A); commit_poll("R10 fill");
    for (int i = 0; i < N; i++) model[i] = 'h5A;
    read_seq(9'h1FE, 4, "R4 wrap after fill");
    frame(2'b00, 9'h100); commit_poll("R10 clear");
    for (int i = 0; i < N; i++) model[i] = 'hFF;
    read_seq(9'h1FF, 2, "R10 clear all");

    // R8/R4 sweep: fill every page, read all plus wrap
    for (int p = 0; p < N / 16; p++) begin
      frame(2'b01, 9'(p * 16));
      for (int s = 0; s < 16; s++) begin
        int a;
        a = p * 16 + s;
        model[a] = (a * 37 + (a >> 3)) & 'hFF;
        send_byte(8'(model[a]));
      end
      cs = 1'b0; tick(2 * H);
      wait_ready();
    end
    read_seq(0, N + 1, "R4 sweep");

    // R6 disable then write has no effect, reads still work
    frame(2'b00, 9'h000); desel();
    frame(2'b01, 9'h000); send_byte(8'h00); desel();
    cs = 1'b1; tick(H); chk("R6 disabled no cycle", do_oe, 0); desel();
    read_seq(0, 1, "R6 after disable");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule